// File: doc/BRIEF.md
# Successive-Approximation Converter Sequencer with Serial Readout

This block is the digital half of a 12-bit successive-approximation converter. It drives the trial code of an external capacitor DAC and takes back a single comparator decision. The result goes out on a one-wire serial output that can be tri-stated. A host starts a conversion by pulling the active-low select low. Each serial clock falling edge then advances one frame position. After a short run of leading zeros, every falling edge also resolves one result bit, which is shifted out at once, most significant bit first. Conversion and readout are therefore one process.

Raising the select at any time ends the frame at once. The data output is released, and the bits resolved so far remain as a coarser result with the unresolved bits at zero. The block is in its low-power static state whenever select is high. After reset, a power-on timer of a set number of clock cycles must expire before a falling select is accepted.

All inputs are sampled on a single system clock `clk`. The serial clock and the select must be synchronous to it and held for at least one `clk` cycle per level.

Top module: `sar_serial_adc`

## Requirements
- R1: During and right after reset, `ready_o`, `conv_o`, `acq_o` and `dout_oe` are low, and `static_o` is high.
- R2: `ready_o` rises exactly `POR_CYCLES` clock cycles after reset is released. A select falling edge seen while `ready_o` is low starts no conversion.
- R3: In the clock cycle after a select falling edge (with the block ready and idle), `conv_o` is high, `acq_o` is low, `dout_oe` is high, `dac_code` equals mid-scale (bit 11 alone set, 0x800) and `dout` is 0.
- R4: The frame is 16 positions. After k serial clock falls, `dout` shows 0 for k < 4, and result bit 15-k for 4 ≤ k ≤ 15.
- R5: At fall k (4 ≤ k ≤ 15), result bit b = 15-k takes the comparator value. `dac_code` then becomes the bits decided so far with bit b-1 set, or just the decided bits when b = 0. With an ideal comparator (high when input ≥ `dac_code`), the full result equals the input code in straight binary.
- R6: On the 16th fall `dout_oe` and `conv_o` drop, `acq_o` rises, and `code_o` holds the full 12-bit result.
- R7: If select rises during a conversion, `dout_oe` and `conv_o` are low in the next cycle. `code_o` keeps the bits decided so far, and undecided bits read 0.
- R8: `static_o` follows the select level with one clock of delay, and `dout_oe` is never high while `static_o` is high.
- R9: A new select falling edge clears `code_o` to 0, sets `dac_code` back to mid-scale and restarts the frame at position 0.
- R10: While converting, `dout` changes only in the cycle after a serial clock falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock, synchronous to clk |
| cs_n | input | 1 | Active-low select; a falling edge starts a frame |
| cmp_hi | input | 1 | Comparator decision: 1 when the held input is at or above the DAC trial |
| dac_code | output | 12 | Trial code for the capacitor DAC |
| dout | output | 1 | Serial data bit |
| dout_oe | output | 1 | Output enable for dout; low means high impedance |
| code_o | output | 12 | Result register (partial after an early abort) |
| conv_o | output | 1 | Conversion phase flag |
| acq_o | output | 1 | Acquisition phase flag |
| static_o | output | 1 | Low-power static flag |
| ready_o | output | 1 | Power-on timer expired |

## Verification
Full conversions are swept across the input range in steps of seven, plus the corner codes 0, 1, 0x7FF, 0x800, 0xFFE and 0xFFF. At each frame position the bench checks the serial bit and the DAC trial, so a wrong bit order, a wrong step halving or a wrong comparator polarity shows up at the exact position where it first goes wrong. Aborts at every fall count from 0 to 15 are run on several input codes with mixed bit patterns, which tells correct partial masking apart from off-by-one bit retention. A select pulse during the power-on window and back-to-back frames on different codes separate a missing timer gate from a missing restart.

// File: rtl/sar_pkg.sv
package sar_pkg;
    typedef enum logic [1:0] {
        PH_POR  = 2'd0,
        PH_ACQ  = 2'd1,
        PH_CONV = 2'd2
    } phase_e;
endpackage

// File: rtl/sar_fall_det.sv
module sar_fall_det #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sig,
    output logic [W-1:0] fall
);
    logic [W-1:0] last_q;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) last_q[i] <= 1'b1;
            else        last_q[i] <= sig[i];
        end
        assign fall[i] = last_q[i] & ~sig[i];
    end
endmodule

// File: rtl/sar_por.sv
module sar_por #(
    parameter int CYCLES = 125000
) (
    input  logic clk,
    input  logic rst_n,
    output logic ready
);
    localparam int CW = $clog2(CYCLES + 1);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (cnt_q != CW'(CYCLES)) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign ready = (cnt_q == CW'(CYCLES));
endmodule

// File: rtl/sar_seq.sv
module sar_seq
    import sar_pkg::*;
#(
    parameter int RES  = 12,
    parameter int LEAD = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ready,
    input  logic           cs_lvl,
    input  logic           cs_fall,
    input  logic           sclk_fall,
    input  logic           cmp_hi,
    output logic [RES-1:0] dac,
    output logic [RES-1:0] code,
    output logic           dout,
    output logic           oe,
    output logic           conv,
    output logic           acq,
    output logic           stat
);
    localparam int FRAME = LEAD + RES;
    localparam int CW    = $clog2(FRAME + 1);
    localparam logic [RES-1:0] MID = RES'(1) << (RES - 1);

    typedef struct packed {
        phase_e         phase;
        logic [CW-1:0]  pos;
        logic [RES-1:0] res;
        logic [RES-1:0] trial;
        logic           cs_hi;
    } st_t;

    st_t st_d, st_q;
    logic [CW-1:0] pos_nx;

    always_comb begin
        st_d       = st_q;
        st_d.cs_hi = cs_lvl;
        pos_nx     = st_q.pos + 1'b1;
        unique case (st_q.phase)
            PH_POR: begin
                if (ready) st_d.phase = PH_ACQ;
            end
            PH_ACQ: begin
                if (cs_fall) begin
                    st_d.phase = PH_CONV;
                    st_d.pos   = '0;
                    st_d.res   = '0;
                    st_d.trial = MID;
                end
            end
            PH_CONV: begin
                if (cs_lvl) begin
                    st_d.phase = PH_ACQ;
                end else if (sclk_fall) begin
                    st_d.pos = pos_nx;
                    for (int i = 0; i < RES; i++) begin
                        if (pos_nx == CW'(FRAME - 1 - i)) begin
                            st_d.res[i] = cmp_hi;
                            st_d.trial  = st_d.res | ((RES'(1) << i) >> 1);
                        end
                    end
                    if (pos_nx == CW'(FRAME)) st_d.phase = PH_ACQ;
                end
            end
            default: st_d.phase = PH_POR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= PH_POR;
            st_q.pos   <= '0;
            st_q.res   <= '0;
            st_q.trial <= MID;
            st_q.cs_hi <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        dout = 1'b0;
        if (st_q.phase == PH_CONV) begin
            for (int i = 0; i < RES; i++) begin
                if (st_q.pos == CW'(FRAME - 1 - i)) dout = st_q.res[i];
            end
        end
    end

    assign dac  = st_q.trial;
    assign code = st_q.res;
    assign oe   = (st_q.phase == PH_CONV);
    assign conv = (st_q.phase == PH_CONV);
    assign acq  = (st_q.phase == PH_ACQ);
    assign stat = st_q.cs_hi;
endmodule

// File: rtl/sar_serial_adc.sv
module sar_serial_adc #(
    parameter int RES        = 12,
    parameter int LEAD       = 4,
    parameter int POR_CYCLES = 125000
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sclk,
    input  logic           cs_n,
    input  logic           cmp_hi,
    output logic [RES-1:0] dac_code,
    output logic           dout,
    output logic           dout_oe,
    output logic [RES-1:0] code_o,
    output logic           conv_o,
    output logic           acq_o,
    output logic           static_o,
    output logic           ready_o
);
    logic [1:0] fall_w;

    sar_fall_det #(.W(2)) u_edges (
        .clk  (clk),
        .rst_n(rst_n),
        .sig  ({cs_n, sclk}),
        .fall (fall_w)
    );

    sar_por #(.CYCLES(POR_CYCLES)) u_por (
        .clk  (clk),
        .rst_n(rst_n),
        .ready(ready_o)
    );

    sar_seq #(.RES(RES), .LEAD(LEAD)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .ready    (ready_o),
        .cs_lvl   (cs_n),
        .cs_fall  (fall_w[1]),
        .sclk_fall(fall_w[0]),
        .cmp_hi   (cmp_hi),
        .dac      (dac_code),
        .code     (code_o),
        .dout     (dout),
        .oe       (dout_oe),
        .conv     (conv_o),
        .acq      (acq_o),
        .stat     (static_o)
    );
endmodule

// File: rtl/sar_adc_checker.sv
module sar_adc_checker #(
    parameter int RES = 12
) (
    input logic           clk,
    input logic           rst_n,
    input logic           sclk_fall,
    input logic           conv,
    input logic           oe,
    input logic           dout,
    input logic           stat,
    input logic           ready,
    input logic [RES-1:0] dac,
    input logic [RES-1:0] code
);
    localparam logic [RES-1:0] MID = RES'(1) << (RES - 1);

    p_no_conv_before_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> !conv);

    p_mid_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(conv) |-> (dac == MID && dout == 1'b0));

    p_hiz_when_static_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stat |-> !oe);

    p_code_cleared_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(conv) |-> code == '0);

    p_dout_only_on_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (conv && $past(conv) && !$past(sclk_fall)) |-> $stable(dout));
endmodule

bind sar_serial_adc sar_adc_checker #(.RES(RES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sclk_fall(fall_w[0]),
    .conv     (conv_o),
    .oe       (dout_oe),
    .dout     (dout),
    .stat     (static_o),
    .ready    (ready_o),
    .dac      (dac_code),
    .code     (code_o)
);

// File: tb/test_sar_serial_adc.sv
`timescale 1ns/1ps
module test_sar_serial_adc;
    localparam int RES  = 12;
    localparam int LEAD = 4;
    localparam int PORC = 20;
    localparam int FRAME = RES + LEAD;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0;
    logic cs_n = 1'b1;
    logic cmp_hi;
    logic [RES-1:0] dac_code, code_o;
    logic dout, dout_oe, conv_o, acq_o, static_o, ready_o;
    logic [RES-1:0] vin = '0;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    assign cmp_hi = (vin >= dac_code);

    sar_serial_adc #(.RES(RES), .LEAD(LEAD), .POR_CYCLES(PORC)) i_sar_serial_adc (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .cmp_hi(cmp_hi),
        .dac_code(dac_code), .dout(dout), .dout_oe(dout_oe), .code_o(code_o),
        .conv_o(conv_o), .acq_o(acq_o), .static_o(static_o), .ready_o(ready_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int keep_top(input int v, input int nb);
        int m = 0;
        for (int i = 0; i < nb; i++) m |= 1 << (RES - 1 - i);
        return v & m;
    endfunction

    function automatic int trial_after(input int v, input int k);
        int b;
        if (k < LEAD) return 1 << (RES - 1);
        b = FRAME - 1 - k;
        return (v & ~((1 << b) - 1)) | ((1 << b) >> 1);
    endfunction

    // One frame: select low, nf serial clock falls, then select high.
    task automatic frame(input int v, input int nf);
        int nd;
        vin = RES'(v);
        @(negedge clk) cs_n = 1'b0;
        @(negedge clk);
        chk("R3 conv", int'(conv_o), 1);
        chk("R3 acq", int'(acq_o), 0);
        chk("R3 oe", int'(dout_oe), 1);
        chk("R3/R9 dac mid", int'(dac_code), 1 << (RES - 1));
        chk("R9 code cleared", int'(code_o), 0);
        chk("R8 static low", int'(static_o), 0);
        for (int k = 1; k <= nf; k++) begin
            @(negedge clk) sclk = 1'b1;
            @(negedge clk) sclk = 1'b0;
            @(negedge clk);
            if (k < FRAME) begin
                chk("R4 dout", int'(dout), (k < LEAD) ? 0 : ((v >> (FRAME - 1 - k)) & 1));
                chk("R5 dac", int'(dac_code), trial_after(v, k));
            end else begin
                chk("R6 oe", int'(dout_oe), 0);
                chk("R6 conv", int'(conv_o), 0);
                chk("R6 acq", int'(acq_o), 1);
                chk("R6/R5 code", int'(code_o), v);
            end
        end
        @(negedge clk) cs_n = 1'b1;
        @(negedge clk);
        nd = (nf < LEAD) ? 0 : ((nf - LEAD + 1 > RES) ? RES : nf - LEAD + 1);
        chk("R7 oe", int'(dout_oe), 0);
        chk("R7 conv", int'(conv_o), 0);
        chk("R7 code", int'(code_o), keep_top(v, nd));
        chk("R8 static", int'(static_o), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 ready", int'(ready_o), 0);
        chk("R1 oe", int'(dout_oe), 0);
        chk("R1 conv", int'(conv_o), 0);
        chk("R1 acq", int'(acq_o), 0);
        chk("R1 static", int'(static_o), 1);
        rst_n = 1'b1;
        for (int c = 1; c <= PORC + 1; c++) begin
            @(negedge clk);
            if (c == 3) cs_n = 1'b0;
            if (c == 6) cs_n = 1'b1;
            if (c == PORC - 1) chk("R2 ready early", int'(ready_o), 0);
            if (c == PORC) chk("R2 ready", int'(ready_o), 1);
            chk("R2 no conv", int'(conv_o), 0);
        end
        @(negedge clk);
        chk("R2 acq", int'(acq_o), 1);

        for (int v = 0; v < (1 << RES); v += 7) frame(v, FRAME);
        frame(0, FRAME); frame(1, FRAME); frame(12'h7FF, FRAME);
        frame(12'h800, FRAME); frame(12'hFFE, FRAME); frame(12'hFFF, FRAME);
        for (int k = 0; k < FRAME; k++) begin
            frame(12'hA5C, k);
            frame(12'h3B7, k);
            frame(12'hFFF, k);
        end
        frame(12'h123, FRAME);
        frame(12'hEDC, 9);
        frame(12'h456, FRAME);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        finished = 1'b1;
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule